// File: doc/BRIEF.md
# Delay-Buffered Leaky Integrate-and-Fire Neuron Array

This block holds a population of leaky integrate-and-fire neurons that share one update datapath. The neurons are processed in turn, one per clock. Synaptic input does not reach a neuron at once. Each incoming event names a target neuron, a signed weight and a delay in timesteps. The weight is added into the target's own circular schedule buffer, at the slot that the current timestep pointer plus the delay selects. Several events that land in the same slot add together, and the sum saturates instead of wrapping.

A `tick` pulse starts one timestep. A sweep then visits the neurons from index 0 upward. For each neuron it folds the due slot into the membrane potential, subtracts the leak, and clears that slot. It then compares the potential against the firing level. A neuron that fires emits its index on a valid/ready spike stream, and its potential is reloaded with the configured restart value. After the last neuron, the schedule pointer moves on by one slot.

While a sweep runs, the block raises `busy` and holds new events off with `ev_ready` low. Fetching synapse data, routing spikes between neurons and learning all belong to the surrounding system.

The controller has three states, ST_IDLE, ST_SWEEP and ST_STALL, with these transitions:
- ST_IDLE goes to ST_SWEEP on `tick`.
- ST_SWEEP goes to ST_STALL when a firing neuron finds the spike register still full and not being taken.
- ST_STALL goes back to ST_SWEEP once that neuron completes.
- Either sweep state returns to ST_IDLE when the last neuron completes.

Top module: `lif_delay_array`

## Requirements
- R1: A synchronous reset clears every potential, every schedule slot, the schedule pointer and the error flag. After reset `busy`, `spk_valid` and `delay_err` are 0 and `ev_ready` is 1.
- R2: An accepted event with delay d, where 1 <= d <= DEPTH-1, adds its weight to slot (pointer + d) mod DEPTH of the target neuron. That input is integrated by the (d+1)-th tick after acceptance, and by no earlier tick.
- R3: For each neuron, a tick computes potential + slot - leak, saturated to the signed POT_W range. If the result is >= the threshold, the neuron spikes and its potential becomes the restart value. Otherwise the potential keeps the result.
- R4: Adding a weight into a schedule slot saturates at the signed SLOT_W range instead of wrapping.
- R5: A slot is cleared once its tick has integrated it, so input scheduled once is never applied again when the pointer wraps around.
- R6: An event with delay 0, a delay >= DEPTH, or a target index >= N_NEURONS is still accepted but changes nothing. It sets `delay_err`, which stays 1 until reset.
- R7: A `tick` in idle starts a sweep. With spikes taken at once, `busy` stays high for exactly N_NEURONS cycles. A `tick` that arrives while `busy` is high is ignored.
- R8: `ev_ready` is 0 whenever `busy` is 1.
- R9: Spikes leave as a valid/ready stream of neuron indices, in ascending order within a timestep. `spk_index` holds stable while `spk_valid` is 1 and `spk_ready` is 0, and the sweep pauses until the spike is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Starts one timestep sweep |
| cfg_leak | input | POT_W | Signed leak subtracted per tick |
| cfg_thresh | input | POT_W | Signed firing level |
| cfg_restart | input | POT_W | Signed potential loaded after a spike |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted this cycle when valid |
| ev_weight | input | WEIGHT_W | Signed synaptic weight |
| ev_delay | input | DELAY_W | Delay in timesteps |
| ev_target | input | IDX_W | Target neuron index |
| busy | output | 1 | Sweep in progress |
| spk_valid | output | 1 | Spike index available |
| spk_ready | input | 1 | Consumer takes the spike |
| spk_index | output | IDX_W | Index of the firing neuron |
| delay_err | output | 1 | Sticky flag for dropped events |

## Verification
Events at the shortest delay and at the longest delay (DEPTH-1) show whether the slot offset and its wrap are correct, and whether input arrives early or late. A pair of large equal weights in one slot, and a negative leak that drives the potential past its top, tell saturation apart from two's-complement wrap. Each of these produces a spike only when saturation is in place. A single event followed by more than DEPTH ticks separates clearing a slot from leaving it stale. Three neurons firing together while the consumer stalls show ordering, stability under backpressure and that the sweep pauses; a second tick inside a sweep shows that it is ignored.

// File: rtl/lif_pkg.sv
package lif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_STALL = 2'd2
    } sweep_state_e;

endpackage

// File: rtl/lif_sweep_fsm.sv
module lif_sweep_fsm
    import lif_pkg::*;
#(
    parameter int N_NEURONS = 8,
    parameter int DEPTH     = 32,
    localparam int IDX_W    = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1,
    localparam int PTR_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             fire,
    input  logic             out_free,
    output logic             busy,
    output logic             step,
    output logic [IDX_W-1:0] idx,
    output logic [PTR_W-1:0] head
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_NEURONS - 1);

    sweep_state_e state, state_nx;
    logic         last;

    assign last = (idx == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = tick ? ST_SWEEP : ST_IDLE;
            ST_SWEEP,
            ST_STALL: begin
                if (step) state_nx = last ? ST_IDLE : ST_SWEEP;
                else      state_nx = ST_STALL;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        step = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SWEEP,
            ST_STALL: begin
                busy = 1'b1;
                step = !fire || out_free;
            end
            default: ;
        endcase
    end

    // neuron index and schedule pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            head <= '0;
        end else if (step) begin
            if (last) begin
                idx  <= '0;
                head <= head + PTR_W'(1);
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/lif_slot_bank.sv
module lif_slot_bank #(
    parameter int N_NEURONS = 8,
    parameter int DEPTH     = 32,
    parameter int WEIGHT_W  = 18,
    parameter int SLOT_W    = 18,
    localparam int IDX_W    = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1,
    localparam int PTR_W    = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       add_en,
    input  logic [IDX_W-1:0]           add_nrn,
    input  logic [PTR_W-1:0]           add_ptr,
    input  logic signed [WEIGHT_W-1:0] add_w,
    input  logic                       clr_en,
    input  logic [IDX_W-1:0]           cur_nrn,
    input  logic [PTR_W-1:0]           cur_ptr,
    output logic signed [SLOT_W-1:0]   cur_slot
);

    localparam logic signed [SLOT_W-1:0] S_MAX = {1'b0, {(SLOT_W-1){1'b1}}};
    localparam logic signed [SLOT_W-1:0] S_MIN = {1'b1, {(SLOT_W-1){1'b0}}};

    logic signed [SLOT_W-1:0] row_rd [N_NEURONS];

    for (genvar g = 0; g < N_NEURONS; g++) begin : g_row
        logic signed [SLOT_W-1:0] cells [DEPTH];
        logic        [SLOT_W:0]   acc;
        logic signed [SLOT_W-1:0] acc_sat;

        always_comb begin
            acc = {cells[add_ptr][SLOT_W-1], cells[add_ptr]} + (SLOT_W+1)'(add_w);
            if (acc[SLOT_W] != acc[SLOT_W-1]) acc_sat = acc[SLOT_W] ? S_MIN : S_MAX;
            else                               acc_sat = acc[SLOT_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < DEPTH; k++) cells[k] <= '0;
            end else if (add_en && add_nrn == IDX_W'(g)) begin
                cells[add_ptr] <= acc_sat;
            end else if (clr_en && cur_nrn == IDX_W'(g)) begin
                cells[cur_ptr] <= '0;
            end
        end

        assign row_rd[g] = cells[cur_ptr];
    end

    assign cur_slot = row_rd[cur_nrn];

endmodule

// File: rtl/lif_update.sv
module lif_update #(
    parameter int POT_W  = 24,
    parameter int SLOT_W = 18
) (
    input  logic signed [POT_W-1:0]  pot_in,
    input  logic signed [SLOT_W-1:0] slot_in,
    input  logic signed [POT_W-1:0]  leak,
    input  logic signed [POT_W-1:0]  thresh,
    output logic signed [POT_W-1:0]  pot_out,
    output logic                     fire
);

    localparam logic signed [POT_W+1:0] P_MAX = {3'b000, {(POT_W-1){1'b1}}};
    localparam logic signed [POT_W+1:0] P_MIN = {3'b111, {(POT_W-1){1'b0}}};

    logic signed [POT_W+1:0] wide;

    always_comb begin
        wide = (POT_W+2)'(pot_in) + (POT_W+2)'(slot_in) - (POT_W+2)'(leak);
        if (wide > P_MAX)      pot_out = P_MAX[POT_W-1:0];
        else if (wide < P_MIN) pot_out = P_MIN[POT_W-1:0];
        else                   pot_out = wide[POT_W-1:0];
        fire = (pot_out >= thresh);
    end

endmodule

// File: rtl/lif_delay_array.sv
module lif_delay_array #(
    parameter int N_NEURONS = 8,
    parameter int DEPTH     = 32,
    parameter int WEIGHT_W  = 18,
    parameter int DELAY_W   = 6,
    parameter int SLOT_W    = 18,
    parameter int POT_W     = 24,
    localparam int IDX_W    = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1,
    localparam int PTR_W    = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic signed [POT_W-1:0]    cfg_leak,
    input  logic signed [POT_W-1:0]    cfg_thresh,
    input  logic signed [POT_W-1:0]    cfg_restart,
    input  logic                       ev_valid,
    output logic                       ev_ready,
    input  logic signed [WEIGHT_W-1:0] ev_weight,
    input  logic [DELAY_W-1:0]         ev_delay,
    input  logic [IDX_W-1:0]           ev_target,
    output logic                       busy,
    output logic                       spk_valid,
    input  logic                       spk_ready,
    output logic [IDX_W-1:0]           spk_index,
    output logic                       delay_err
);

    localparam logic [DELAY_W:0] DEPTH_D = (DELAY_W+1)'(DEPTH);
    localparam logic [IDX_W:0]   NCOUNT  = (IDX_W+1)'(N_NEURONS);

    logic                     step;
    logic                     fire;
    logic                     out_free;
    logic [IDX_W-1:0]         idx;
    logic [PTR_W-1:0]         head;
    logic signed [SLOT_W-1:0] cur_slot;
    logic signed [POT_W-1:0]  pot_next;
    logic signed [POT_W-1:0]  pot [N_NEURONS];

    logic ev_take, ev_ok, add_en;
    logic [PTR_W-1:0] add_ptr;

    assign ev_ready = !busy;
    assign ev_take  = ev_valid && ev_ready;
    assign ev_ok    = (ev_delay != '0) && ({1'b0, ev_delay} < DEPTH_D)
                   && ({1'b0, ev_target} < NCOUNT);
    assign add_en   = ev_take && ev_ok;
    assign add_ptr  = head + ev_delay[PTR_W-1:0];
    assign out_free = !spk_valid || spk_ready;

    lif_sweep_fsm #(.N_NEURONS(N_NEURONS), .DEPTH(DEPTH)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .fire     (fire),
        .out_free (out_free),
        .busy     (busy),
        .step     (step),
        .idx      (idx),
        .head     (head)
    );

    lif_slot_bank #(
        .N_NEURONS (N_NEURONS),
        .DEPTH     (DEPTH),
        .WEIGHT_W  (WEIGHT_W),
        .SLOT_W    (SLOT_W)
    ) u_slots (
        .clk      (clk),
        .rst      (rst),
        .add_en   (add_en),
        .add_nrn  (ev_target),
        .add_ptr  (add_ptr),
        .add_w    (ev_weight),
        .clr_en   (step),
        .cur_nrn  (idx),
        .cur_ptr  (head),
        .cur_slot (cur_slot)
    );

    lif_update #(.POT_W(POT_W), .SLOT_W(SLOT_W)) u_upd (
        .pot_in  (pot[idx]),
        .slot_in (cur_slot),
        .leak    (cfg_leak),
        .thresh  (cfg_thresh),
        .pot_out (pot_next),
        .fire    (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_NEURONS; i++) pot[i] <= '0;
        end else if (step) begin
            pot[idx] <= fire ? cfg_restart : pot_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spk_valid <= 1'b0;
            spk_index <= '0;
        end else if (step && fire) begin
            spk_valid <= 1'b1;
            spk_index <= idx;
        end else if (spk_ready) begin
            spk_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 delay_err <= 1'b0;
        else if (ev_take && !ev_ok) delay_err <= 1'b1;
    end

endmodule

// File: rtl/lif_delay_array_chk.sv
module lif_delay_array_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             ev_valid,
    input logic             ev_ready,
    input logic             busy,
    input logic             spk_valid,
    input logic             spk_ready,
    input logic [IDX_W-1:0] spk_index,
    input logic             delay_err
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !spk_valid && !delay_err));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        delay_err |=> delay_err);

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(delay_err) |-> $past(ev_valid && ev_ready));

    assert_sweep_needs_tick_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick));

    assert_no_event_in_sweep_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ev_ready);

    assert_spike_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (spk_valid && !spk_ready) |=> (spk_valid && $stable(spk_index)));

    assert_spike_from_sweep_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(spk_valid) |-> $past(busy));

endmodule

bind lif_delay_array lif_delay_array_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ev_valid  (ev_valid),
    .ev_ready  (ev_ready),
    .busy      (busy),
    .spk_valid (spk_valid),
    .spk_ready (spk_ready),
    .spk_index (spk_index),
    .delay_err (delay_err)
);

// File: tb/tb_lif_delay_array.sv
`timescale 1ns/1ps
module tb_lif_delay_array;

    localparam int N     = 8;
    localparam int DEPTH = 32;
    localparam int WW    = 18;
    localparam int DW    = 6;
    localparam int SW    = 18;
    localparam int PW    = 24;
    localparam int IW    = 3;

    logic clk = 0;
    logic rst = 1;
    logic tick = 0;
    logic signed [PW-1:0] cfg_leak = '0, cfg_thresh = '0, cfg_restart = '0;
    logic ev_valid = 0;
    logic ev_ready;
    logic signed [WW-1:0] ev_weight = '0;
    logic [DW-1:0] ev_delay = '0;
    logic [IW-1:0] ev_target = '0;
    logic busy, spk_valid, delay_err;
    logic spk_ready = 1;
    logic [IW-1:0] spk_index;

    always #10 clk = ~clk;

    lif_delay_array dut (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_leak(cfg_leak), .cfg_thresh(cfg_thresh), .cfg_restart(cfg_restart),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_weight(ev_weight),
        .ev_delay(ev_delay), .ev_target(ev_target),
        .busy(busy), .spk_valid(spk_valid), .spk_ready(spk_ready),
        .spk_index(spk_index), .delay_err(delay_err)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // model built from the requirements
    longint pot_m [N];
    longint slot_m [N][DEPTH];
    int     head_m;
    bit     err_m;
    int     got_q[$];
    int     exp_q[$];

    always @(negedge clk)
        if (!rst && spk_valid && spk_ready) got_q.push_back(int'(spk_index));

    function automatic longint sat(longint v, int w);
        longint hi = (longint'(1) <<< (w-1)) - 1;
        longint lo = -(longint'(1) <<< (w-1));
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    task automatic check(string req, longint act, longint exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; tick = 0; ev_valid = 0; spk_ready = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        for (int i = 0; i < N; i++) begin
            pot_m[i] = 0;
            for (int k = 0; k < DEPTH; k++) slot_m[i][k] = 0;
        end
        head_m = 0; err_m = 0;
        got_q.delete();
    endtask

    task automatic set_cfg(longint leak, longint thr, longint rs);
        @(negedge clk);
        cfg_leak = PW'(leak); cfg_thresh = PW'(thr); cfg_restart = PW'(rs);
    endtask

    task automatic send_event(longint w, int d, int t);
        @(negedge clk);
        ev_valid = 1; ev_weight = WW'(w); ev_delay = DW'(d); ev_target = IW'(t);
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 0;
        if (d >= 1 && d < DEPTH && t < N)
            slot_m[t][(head_m + d) % DEPTH] = sat(slot_m[t][(head_m + d) % DEPTH] + w, SW);
        else
            err_m = 1;
    endtask

    function automatic void model_tick();
        exp_q.delete();
        for (int i = 0; i < N; i++) begin
            longint p = sat(pot_m[i] + slot_m[i][head_m] - longint'(cfg_leak), PW);
            slot_m[i][head_m] = 0;
            if (p >= longint'(cfg_thresh)) begin
                exp_q.push_back(i);
                pot_m[i] = longint'(cfg_restart);
            end else begin
                pot_m[i] = p;
            end
        end
        head_m = (head_m + 1) % DEPTH;
    endfunction

    task automatic compare_spikes(string req);
        check(req, got_q.size(), exp_q.size(), "spike count");
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(req, got_q[i], exp_q[i], "spike index");
    endtask

    // one timestep; extra=1 pulses a second tick inside the sweep
    task automatic run_tick(string req, bit extra, output int busy_cycles);
        @(negedge clk);
        got_q.delete();
        model_tick();
        tick = 1;
        @(negedge clk);
        tick = extra;
        busy_cycles = 0;
        while (busy) begin
            busy_cycles++;
            @(negedge clk);
            tick = 0;
        end
        tick = 0;
        repeat (2) @(negedge clk);
        #1;
        compare_spikes(req);
    endtask

    task automatic ticks(string req, int n);
        int bc;
        for (int i = 0; i < n; i++) run_tick(req, 0, bc);
    endtask

    // R1
    task automatic t_reset();
        int bc;
        do_reset();
        #1;
        check("R1", busy, 0, "busy after reset");
        check("R1", spk_valid, 0, "spk_valid after reset");
        check("R1", delay_err, 0, "delay_err after reset");
        check("R1", ev_ready, 1, "ev_ready after reset");
        set_cfg(0, 10, 0);
        send_event(100, 1, 4);
        send_event(0, 0, 0);
        run_tick("R1", 0, bc);
        do_reset();
        #1;
        check("R1", delay_err, 0, "delay_err cleared by reset");
        ticks("R1", 3);
    endtask

    // R2: shortest and longest delays
    task automatic t_delay();
        do_reset();
        set_cfg(0, 100, 0);
        send_event(150, 3, 2);
        send_event(150, DEPTH-1, 5);
        send_event(150, 1, 0);
        ticks("R2", DEPTH + 1);
    endtask

    // R3: leak, restart and potential saturation
    task automatic t_leak();
        do_reset();
        set_cfg(10, 100, -20);
        send_event(60, 1, 0);
        send_event(60, 2, 0);
        send_event(130, 1, 1);
        send_event(-500, 2, 6);
        ticks("R3", 5);
        do_reset();
        set_cfg(-8000000, 8388607, 0);
        ticks("R3", 3);
    endtask

    // R4: slot accumulation saturates
    task automatic t_slot_sat();
        do_reset();
        set_cfg(0, 100000, 0);
        send_event(131071, 2, 3);
        send_event(131071, 2, 3);
        send_event(-131072, 2, 4);
        send_event(-131072, 2, 4);
        send_event(131071, 2, 4);
        ticks("R4", 4);
    endtask

    // R5: consumed slots are cleared
    task automatic t_clear();
        do_reset();
        set_cfg(0, 50, 0);
        send_event(80, 1, 7);
        ticks("R5", DEPTH + 3);
    endtask

    // R6: bad delay or target
    task automatic t_bad_event();
        do_reset();
        set_cfg(0, 10, 0);
        send_event(500, 1, 1);
        #1;
        check("R6", delay_err, 0, "flag after valid event");
        send_event(500, 0, 0);
        #1;
        check("R6", delay_err, 1, "flag after delay 0");
        send_event(500, DEPTH, 2);
        send_event(500, DEPTH + 1, 3);
        ticks("R6", 3);
        #1;
        check("R6", delay_err, 1, "flag stays set");
        check("R6", longint'(err_m), 1, "model flag");
    endtask

    // R7 / R8: sweep length and ignored tick
    task automatic t_busy();
        int bc;
        do_reset();
        set_cfg(0, 50, 0);
        run_tick("R7", 0, bc);
        check("R7", bc, N, "busy cycles");
        send_event(100, 2, 0);
        run_tick("R7", 1, bc);
        check("R7", bc, N, "busy cycles with extra tick");
        run_tick("R7", 0, bc);
        run_tick("R7", 0, bc);
    endtask

    // R8 / R9: ordering and backpressure
    task automatic t_backpressure();
        int bc;
        do_reset();
        set_cfg(0, 10, 0);
        send_event(50, 1, 6);
        send_event(50, 1, 1);
        send_event(50, 1, 3);
        run_tick("R9", 0, bc);
        @(negedge clk);
        got_q.delete();
        model_tick();
        spk_ready = 0;
        tick = 1;
        @(negedge clk);
        tick = 0;
        #1;
        check("R8", ev_ready, 0, "ev_ready during sweep");
        repeat (12) @(negedge clk);
        #1;
        check("R9", busy, 1, "sweep paused");
        check("R9", spk_valid, 1, "spike held");
        check("R9", spk_index, 1, "held index");
        check("R8", ev_ready, 0, "ev_ready while paused");
        @(negedge clk);
        spk_ready = 1;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
        compare_spikes("R9");
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_delay();
        t_leak();
        t_slot_sat();
        t_clear();
        t_bad_event();
        t_busy();
        t_backpressure();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule